// File: doc/BRIEF.md
# Time-Marker Coincidence Track Matcher

This block gathers track-stub records from several front-end input channels and decides which of them form a track. Every stub carries a position code, an angle pattern code and a time marker taken from a 12-bit wrapping counter. The block compares the markers carried in the data, never the cycle in which a stub happened to arrive. Inputs from different channels may therefore come in skewed by any amount that the latency limit allows.

Each channel keeps its pending stubs in a small store. A seed scanner visits one stored stub per cycle. For every other channel it looks for the lowest-slot live stub whose marker lies within a programmable tolerance of the seed's marker. When at least a programmed number of channels contribute, the block raises a one-cycle accept that carries a time marker. In the same cycle it emits a log record naming the contributing channels and their stub contents. Contributing stubs are consumed. Stubs that grow older than a programmable age limit are dropped without ever being reported.

Top module: `tmm_track_matcher`

## Requirements
- R1: After reset `l1a_valid` and `log_valid` are low and every bit of `stub_ready` is high.
- R2: An accept occurs when a live seed stub plus the other channels holding a live stub within the tolerance of the seed number at least `cfg_min_hits` channels. `log_mask` bit c is set for every such channel, one stub each.
- R3: Two markers agree when the magnitude of their difference, taken as a signed 12-bit modular value, is at most `cfg_window`. A difference of `cfg_window`+1 does not agree.
- R4: `l1a_valid` is a one-cycle pulse per track, and `l1a_time` equals the marker of the contributing stub on the lowest-numbered channel in `log_mask`.
- R5: `log_valid` pulses together with `l1a_valid`. Field c of `log_pos` and `log_pat` holds the contributing stub of channel c, or zero when bit c of `log_mask` is clear.
- R6: A stored stub whose age, `now` minus its marker taken as a signed 12-bit value, exceeds `cfg_max_age` is dropped and never contributes to a later track.
- R7: A stub that has contributed to an accepted track is removed and cannot cause a second accept, even after `cfg_min_hits` is lowered.
- R8: The order and cycle spacing in which the stubs of a track arrive on their channels do not change the result.
- R9: Marker agreement holds across the wrap from 4095 to 0.
- R10: `stub_ready[c]` is low while channel c holds DEPTH (default 8) live stubs. It returns high once any of them is dropped or consumed.
- R11: Once all stubs of a qualifying group are stored, the accept appears within NCH*DEPTH+2 clock cycles. At the decision point no contributing stub is older than `cfg_max_age`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now | input | 12 | Current time marker used for aging |
| cfg_window | input | 11 | Marker agreement tolerance |
| cfg_max_age | input | 11 | Age above which a stub is dropped |
| cfg_min_hits | input | 2 | Minimum number of contributing channels |
| stub_valid | input | NCH | Per-channel stub valid |
| stub_ready | output | NCH | Per-channel store has a free slot |
| stub_pos | input | NCH*7 | Per-channel position code |
| stub_pat | input | NCH*4 | Per-channel angle pattern code |
| stub_time | input | NCH*12 | Per-channel time marker |
| l1a_valid | output | 1 | Accept strobe |
| l1a_time | output | 12 | Marker carried by the accept |
| log_valid | output | 1 | Track log record valid |
| log_mask | output | NCH | Contributing channels |
| log_pos | output | NCH*7 | Position codes of contributing stubs |
| log_pat | output | NCH*4 | Pattern codes of contributing stubs |

## Verification
The bench sends identical markers on all channels, and then markers spread exactly to the tolerance and delivered in a scrambled order with idle gaps. The two runs separate marker-based matching from arrival-based matching. A pair of markers one step beyond the tolerance, later aged out and followed by a lower threshold, shows that agreement is judged at the boundary and that aged stubs are truly gone. A two-channel track below a full group, a group straddling the counter wrap, a repeat probe after consumption and a channel filled to capacity cover the threshold, wrap, single-use and backpressure behaviour.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
  parameter int unsigned POS_W = 7;
  parameter int unsigned PAT_W = 4;
  parameter int unsigned TM_W  = 12;

  typedef struct packed {
    logic [POS_W-1:0] pos;
    logic [PAT_W-1:0] pat;
    logic [TM_W-1:0]  tmark;
  } stub_t;

  // signed modular difference a - b
  function automatic logic signed [TM_W-1:0] tm_delta(input logic [TM_W-1:0] a,
                                                      input logic [TM_W-1:0] b);
    logic [TM_W-1:0] d;
    d = a - b;
    return $signed(d);
  endfunction
endpackage

// File: rtl/tmm_stub_buf.sv
module tmm_stub_buf
  import tmm_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  stub_t             in_stub,
  input  logic [TM_W-1:0]   now,
  input  logic [TM_W-2:0]   max_age,
  input  logic [DEPTH-1:0]  consume,
  output logic [DEPTH-1:0]  live,
  output logic [DEPTH-1:0]  vld,
  output stub_t [DEPTH-1:0] ent
);
  logic [DEPTH-1:0] vld_q, vld_d, aged, wr_hit;
  logic             wr_en, found;
  stub_t [DEPTH-1:0] ent_q;

  always_comb begin
    wr_hit = '0;
    found  = 1'b0;
    for (int s = 0; s < DEPTH; s++) begin
      aged[s] = vld_q[s] &&
                (tm_delta(now, ent_q[s].tmark) > $signed({1'b0, max_age}));
      if (!vld_q[s] && !found) begin
        wr_hit[s] = 1'b1;
        found     = 1'b1;
      end
    end
    in_ready = ~&vld_q;
    wr_en    = in_valid & in_ready;
    for (int s = 0; s < DEPTH; s++) begin
      vld_d[s] = (wr_en & wr_hit[s]) | (vld_q[s] & ~aged[s] & ~consume[s]);
    end
    live = vld_q & ~aged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (wr_en && wr_hit[s]) ent_q[s] <= in_stub;
    end
  end

  assign vld = vld_q;
  assign ent = ent_q;
endmodule

// File: rtl/tmm_matcher.sv
module tmm_matcher
  import tmm_pkg::*;
#(
  parameter int unsigned NCH   = 3,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(NCH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH-1:0][DEPTH-1:0]   live,
  input  stub_t [NCH-1:0][DEPTH-1:0]  ent,
  input  logic [TM_W-2:0]             window,
  input  logic [CNT_W-1:0]            min_hits,
  output logic                        accept,
  output logic [NCH-1:0][DEPTH-1:0]   consume,
  output logic [NCH-1:0]              hit_mask,
  output logic [TM_W-1:0]             trk_time,
  output logic [NCH-1:0][POS_W-1:0]   trk_pos,
  output logic [NCH-1:0][PAT_W-1:0]   trk_pat
);
  localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_W-1:0]   sc_q, sc_d;
  logic [SLOT_W-1:0] ss_q, ss_d;
  logic [TM_W-1:0]   seed_t;
  logic              seed_ok;
  logic [NCH-1:0][DEPTH-1:0] pick;
  stub_t [NCH-1:0]   sel;
  logic [CNT_W-1:0]  nhit;

  function automatic logic in_win(input logic [TM_W-1:0] t,
                                  input logic [TM_W-1:0] ref_t,
                                  input logic [TM_W-2:0] w);
    logic signed [TM_W-1:0] d;
    logic [TM_W-1:0]        mag;
    d   = tm_delta(t, ref_t);
    mag = d[TM_W-1] ? (~d + 1'b1) : d;
    return mag <= {1'b0, w};
  endfunction

  // seed scan order: slot first, then channel
  always_comb begin
    if (ss_q == SLOT_W'(DEPTH - 1)) begin
      ss_d = '0;
      sc_d = (sc_q == CH_W'(NCH - 1)) ? '0 : sc_q + 1'b1;
    end else begin
      ss_d = ss_q + 1'b1;
      sc_d = sc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
      ss_q <= '0;
    end else begin
      sc_q <= sc_d;
      ss_q <= ss_d;
    end
  end

  always_comb begin
    seed_t  = ent[sc_q][ss_q].tmark;
    seed_ok = live[sc_q][ss_q];
    nhit    = '0;
    for (int c = 0; c < NCH; c++) begin
      hit_mask[c] = 1'b0;
      pick[c]     = '0;
      sel[c]      = '0;
      if (CH_W'(c) == sc_q) begin
        hit_mask[c]   = seed_ok;
        pick[c][ss_q] = 1'b1;
        sel[c]        = ent[c][ss_q];
      end else begin
        for (int s = DEPTH - 1; s >= 0; s--) begin
          if (live[c][s] && in_win(ent[c][s].tmark, seed_t, window)) begin
            hit_mask[c] = 1'b1;
            pick[c]     = '0;
            pick[c][s]  = 1'b1;
            sel[c]      = ent[c][s];
          end
        end
      end
      nhit = nhit + CNT_W'(hit_mask[c]);
    end
    accept   = seed_ok && (nhit >= min_hits);
    trk_time = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (hit_mask[c]) trk_time = sel[c].tmark;
    end
    for (int c = 0; c < NCH; c++) begin
      consume[c] = (accept && hit_mask[c]) ? pick[c] : '0;
      trk_pos[c] = hit_mask[c] ? sel[c].pos : '0;
      trk_pat[c] = hit_mask[c] ? sel[c].pat : '0;
    end
  end
endmodule

// File: rtl/tmm_track_matcher.sv
module tmm_track_matcher
  import tmm_pkg::*;
#(
  parameter int unsigned NCH   = 3,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(NCH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [TM_W-1:0]           now,
  input  logic [TM_W-2:0]           cfg_window,
  input  logic [TM_W-2:0]           cfg_max_age,
  input  logic [CNT_W-1:0]          cfg_min_hits,
  input  logic [NCH-1:0]            stub_valid,
  output logic [NCH-1:0]            stub_ready,
  input  logic [NCH-1:0][POS_W-1:0] stub_pos,
  input  logic [NCH-1:0][PAT_W-1:0] stub_pat,
  input  logic [NCH-1:0][TM_W-1:0]  stub_time,
  output logic                      l1a_valid,
  output logic [TM_W-1:0]           l1a_time,
  output logic                      log_valid,
  output logic [NCH-1:0]            log_mask,
  output logic [NCH-1:0][POS_W-1:0] log_pos,
  output logic [NCH-1:0][PAT_W-1:0] log_pat
);
  stub_t [NCH-1:0]                 in_stub;
  stub_t [NCH-1:0][DEPTH-1:0]      ent_all;
  logic  [NCH-1:0][DEPTH-1:0]      live_all, vld_all, consume_all;
  logic  [NCH-1:0][DEPTH-1:0][TM_W-1:0] ent_time_all;

  logic                      accept;
  logic [NCH-1:0]            hit_mask;
  logic [TM_W-1:0]           trk_time;
  logic [NCH-1:0][POS_W-1:0] trk_pos;
  logic [NCH-1:0][PAT_W-1:0] trk_pat;

  logic                      acc_q;
  logic [TM_W-1:0]           time_q;
  logic [NCH-1:0]            mask_q;
  logic [NCH-1:0][POS_W-1:0] pos_q;
  logic [NCH-1:0][PAT_W-1:0] pat_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign in_stub[c].pos   = stub_pos[c];
    assign in_stub[c].pat   = stub_pat[c];
    assign in_stub[c].tmark = stub_time[c];

    tmm_stub_buf #(.DEPTH(DEPTH)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (stub_valid[c]),
      .in_ready (stub_ready[c]),
      .in_stub  (in_stub[c]),
      .now      (now),
      .max_age  (cfg_max_age),
      .consume  (consume_all[c]),
      .live     (live_all[c]),
      .vld      (vld_all[c]),
      .ent      (ent_all[c])
    );

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      assign ent_time_all[c][s] = ent_all[c][s].tmark;
    end
  end

  tmm_matcher #(.NCH(NCH), .DEPTH(DEPTH)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live_all),
    .ent      (ent_all),
    .window   (cfg_window),
    .min_hits (cfg_min_hits),
    .accept   (accept),
    .consume  (consume_all),
    .hit_mask (hit_mask),
    .trk_time (trk_time),
    .trk_pos  (trk_pos),
    .trk_pat  (trk_pat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      time_q <= trk_time;
      mask_q <= hit_mask;
      pos_q  <= trk_pos;
      pat_q  <= trk_pat;
    end
  end

  assign l1a_valid = acc_q;
  assign l1a_time  = time_q;
  assign log_valid = acc_q;
  assign log_mask  = mask_q;
  assign log_pos   = pos_q;
  assign log_pat   = pat_q;
endmodule

// File: rtl/tmm_checker.sv
module tmm_checker
  import tmm_pkg::*;
#(
  parameter int unsigned NCH   = 3,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(NCH + 1)
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [TM_W-1:0]                     now,
  input logic [TM_W-2:0]                     cfg_max_age,
  input logic [CNT_W-1:0]                    cfg_min_hits,
  input logic                                l1a_valid,
  input logic [TM_W-1:0]                     l1a_time,
  input logic [NCH-1:0]                      log_mask,
  input logic                                accept,
  input logic [NCH-1:0][DEPTH-1:0]           consume,
  input logic [NCH-1:0][DEPTH-1:0]           vld,
  input logic [NCH-1:0][DEPTH-1:0][TM_W-1:0] ent_time
);
  a_r2_enough_hits: assert property (@(posedge clk) disable iff (!rst_n)
    l1a_valid |-> (log_mask != '0) && ($countones(log_mask) >= $past(cfg_min_hits)));

  a_r11_not_stale: assert property (@(posedge clk) disable iff (!rst_n)
    l1a_valid |-> (tm_delta($past(now), l1a_time) <= $signed({1'b0, $past(cfg_max_age)})));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    for (genvar s = 0; s < DEPTH; s++) begin : g_s
      a_r7_consumed_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && consume[c][s]) |=> !vld[c][s]);

      a_r6_aged_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[c][s] && (tm_delta(now, ent_time[c][s]) > $signed({1'b0, cfg_max_age})))
          |=> !vld[c][s]);
    end
  end
endmodule

bind tmm_track_matcher tmm_checker #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .now          (now),
  .cfg_max_age  (cfg_max_age),
  .cfg_min_hits (cfg_min_hits),
  .l1a_valid    (l1a_valid),
  .l1a_time     (l1a_time),
  .log_mask     (log_mask),
  .accept       (accept),
  .consume      (consume_all),
  .vld          (vld_all),
  .ent_time     (ent_time_all)
);

// File: tb/tb_tmm_track_matcher.sv
module tb_tmm_track_matcher;
  import tmm_pkg::*;
  localparam int NCH = 3;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(NCH + 1);
  localparam int LAT_MAX = NCH * DEPTH + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [TM_W-1:0] now;
  logic [TM_W-2:0] cfg_window, cfg_max_age;
  logic [CNT_W-1:0] cfg_min_hits;
  logic [NCH-1:0] stub_valid, stub_ready;
  logic [NCH-1:0][POS_W-1:0] stub_pos;
  logic [NCH-1:0][PAT_W-1:0] stub_pat;
  logic [NCH-1:0][TM_W-1:0]  stub_time;
  logic l1a_valid, log_valid;
  logic [TM_W-1:0] l1a_time;
  logic [NCH-1:0] log_mask;
  logic [NCH-1:0][POS_W-1:0] log_pos;
  logic [NCH-1:0][PAT_W-1:0] log_pat;

  typedef struct {
    logic [TM_W-1:0]           tm;
    logic [NCH-1:0]            mask;
    logic [NCH-1:0][POS_W-1:0] pos;
    string                     tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, cyc = 0, last_send = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmm_track_matcher #(.NCH(NCH), .DEPTH(DEPTH)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every accept
  always @(negedge clk) begin
    if (rst_n === 1'b1 && l1a_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected accept", int'(log_mask), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(l1a_time == e.tm, {e.tag, " R4 l1a_time"}, int'(l1a_time), int'(e.tm));
        chk(log_mask == e.mask, {e.tag, " R2 log_mask"}, int'(log_mask), int'(e.mask));
        chk(log_pos == e.pos, {e.tag, " R5 log_pos"}, int'(log_pos), int'(e.pos));
        chk(log_valid == 1'b1, {e.tag, " R5 log_valid"}, int'(log_valid), 1);
        chk(cyc - last_send <= LAT_MAX, {e.tag, " R11 latency"}, cyc - last_send, LAT_MAX);
      end
    end
  end

  task automatic expect_trk(input int tm, input int mask, input int p0, input int p1,
                            input int p2, input string tag);
    exp_t e;
    e.tm = TM_W'(tm);
    e.mask = NCH'(mask);
    e.pos[0] = POS_W'(p0);
    e.pos[1] = POS_W'(p1);
    e.pos[2] = POS_W'(p2);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send(input int ch, input int pos, input int pat, input int tm);
    @(negedge clk);
    stub_valid[ch] = 1'b1;
    stub_pos[ch]   = POS_W'(pos);
    stub_pat[ch]   = PAT_W'(pat);
    stub_time[ch]  = TM_W'(tm);
    @(negedge clk);
    stub_valid[ch] = 1'b0;
    last_send = cyc;
  endtask

  task automatic settle(input int n, input string tag);
    repeat (n) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    now = 12'd100;
    cfg_window = 11'd2;
    cfg_max_age = 11'd50;
    cfg_min_hits = 2'd3;
    stub_valid = '0;
    stub_pos = '0;
    stub_pat = '0;
    stub_time = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(l1a_valid == 1'b0, "R1 l1a_valid", int'(l1a_valid), 0);
    chk(log_valid == 1'b0, "R1 log_valid", int'(log_valid), 0);
    chk(stub_ready == 3'b111, "R1 stub_ready", int'(stub_ready), 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R5: identical markers on all channels
    expect_trk(90, 3'b111, 10, 20, 30, "equal");
    send(0, 10, 1, 90);
    send(1, 20, 2, 90);
    send(2, 30, 3, 90);
    settle(40, "R2 equal");

    // R7: consumed stubs do not fire again at a lower threshold
    cfg_min_hits = 2'd1;
    settle(40, "R7 consumed");
    cfg_min_hits = 2'd3;

    // R3 R8: spread exactly to the window, scrambled order with gaps
    expect_trk(95, 3'b111, 5, 6, 7, "skew");
    send(2, 7, 4, 96);
    repeat (7) @(negedge clk);
    send(0, 5, 4, 95);
    repeat (3) @(negedge clk);
    send(1, 6, 4, 97);
    settle(40, "R3 R8 skew");

    // R3: one step beyond the window does not agree
    send(0, 11, 0, 80);
    send(1, 12, 0, 83);
    send(2, 13, 0, 80);
    settle(40, "R3 beyond window");

    // R6: age everything out, then a lower threshold finds nothing
    now = 12'd140;
    repeat (3) @(negedge clk);
    cfg_min_hits = 2'd2;
    settle(40, "R6 aged dropped");

    // R2: two channels meet a threshold of two
    expect_trk(130, 3'b110, 0, 41, 42, "pair");
    send(1, 41, 1, 130);
    send(2, 42, 1, 130);
    settle(40, "R2 pair");
    cfg_min_hits = 2'd3;

    // R9: group straddling the wrap
    now = 12'd3;
    repeat (2) @(negedge clk);
    expect_trk(4094, 3'b111, 50, 51, 52, "wrap");
    send(0, 50, 2, 4094);
    send(1, 51, 2, 4095);
    send(2, 52, 2, 1);
    settle(40, "R9 wrap");

    // R10: fill channel 0 to capacity
    for (int i = 0; i < DEPTH; i++) send(0, i, 0, 0);
    @(negedge clk);
    chk(stub_ready == 3'b110, "R10 full channel", int'(stub_ready), 6);
    now = 12'd63;
    repeat (2) @(negedge clk);
    chk(stub_ready == 3'b111, "R10 R6 freed by aging", int'(stub_ready), 7);
    settle(5, "R10 end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule